// File: doc/BRIEF.md
# DMA Cycle Ready-Handshake Terminator

This block decides the clock on which a single-address DMA bus cycle ends. A cycle opens on a start strobe. It normally closes once the transfer acknowledge from the bus is seen. The acknowledge may also come from an internal fast-termination request. When the channel's ready gating is on, a slow peripheral can hold the cycle open through a ready input. The cycle then closes only when both the acknowledge and the ready input have been seen. Ready has to be seen one clock ahead of the acknowledge if the cycle is to be no longer than an ungated one.

The acknowledge and ready inputs are asynchronous. Each passes through a two-stage synchronizer clocked on the falling edge. The decision logic runs on the rising edge in a three-state machine. `ST_IDLE` moves to `ST_RUN` on a start strobe. `ST_RUN` moves to `ST_DONE` once the termination rule is met. `ST_DONE` drives the one-clock end pulse and always returns to `ST_IDLE`. A clock counter reports the length of the cycle alongside the end pulse. The mode inputs are captured when the cycle starts.

Top module: `dma_rdy_term`

## Requirements
- R1: With ready gating off and no fast request, the acknowledge alone ends the cycle. The end pulse comes one clock after the acknowledge is recognized. An acknowledge driven k clocks after the start edge (k = 0 for the clock right after it) gives `cycle_clocks` = k + 3.
- R2: With `rdy_en` = 1 in single-address mode, an acknowledge does not end the cycle until ready has also been recognized.
- R3: Ready recognized one clock before the acknowledge gives the same length as the acknowledge alone. For ready at r = k - 1, the length is k + 3.
- R4: Ready recognized on the same edge as the acknowledge, or on a later one, sets the timing. The cycle ends two clocks after ready is recognized, giving length r + 4.
- R5: A fast request with ready gating off ends the cycle at 2 clocks with `legacy_mode` = 0, and at 3 clocks with `legacy_mode` = 1.
- R6: A fast request with ready gating on is stretched to at least 3 clocks in native mode and 4 clocks in legacy mode. It is stretched further while ready is not yet recognized.
- R7: Ready held high from before the start lets the acknowledge set the timing (length k + 3). The fast minimums of R6 still apply.
- R8: With `dual_mode` = 1, `rdy_en` is ignored, and a cycle with ready low ends on the acknowledge as in R1.
- R9: Both asynchronous inputs pass through two falling-edge flops before any decision. A level driven just after rising edge n is acted on at rising edge n + 2.
- R10: `cycle_end` is high for exactly one clock per cycle. A `cycle_start` that arrives while a cycle is open is ignored and produces no second end pulse.
- R11: Reset returns the block to idle with `cycle_end` = 0 and `cycle_clocks` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; decisions on rising edge, synchronizers on falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rdy_en | input | 1 | Ready gating enable for this channel |
| dual_mode | input | 1 | 1 = dual-address transfer (ready gating ignored) |
| legacy_mode | input | 1 | 1 = legacy three-clock protocol, 0 = native fast protocol |
| fast_req | input | 1 | Internal fast-termination request for this cycle |
| ext_ack | input | 1 | Asynchronous transfer acknowledge, active high |
| ext_rdy | input | 1 | Asynchronous peripheral ready, active high |
| cycle_start | input | 1 | Start strobe, accepted only when idle |
| cycle_end | output | 1 | One-clock pulse marking the final clock of the cycle |
| cycle_clocks | output | CNT_W | Clocks in the cycle; valid while `cycle_end` is high |

## Verification
The two events that can land on the same clock are acknowledge recognition and ready recognition. The bench provokes this by driving `ext_ack` and `ext_rdy` right after the same rising edge. It then expects the ready rule to win, giving length r + 4 rather than k + 3. Neighbouring offsets (ready one clock earlier, ready much later, ready held from before the start) bracket that edge. Each expected length is queued by the driver and compared by the monitor when the end pulse appears.

// File: rtl/dma_rdy_pkg.sv
package dma_rdy_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } term_state_e;
endpackage

// File: rtl/dma_async_sync.sv
module dma_async_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh;

    // R9: falling-edge capture chain
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-2:0], din};
    end

    assign dout = sh[STAGES-1];
endmodule

// File: rtl/dma_term_fsm.sv
module dma_term_fsm
    import dma_rdy_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int FAST_NATIVE = 2,
    parameter int FAST_LEGACY = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rdy_en,
    input  logic             dual_mode,
    input  logic             legacy_mode,
    input  logic             fast_req,
    input  logic             cycle_start,
    input  logic             ack_sync,
    input  logic             rdy_sync,
    output logic             cycle_end,
    output logic [CNT_W-1:0] cycle_clocks
);
    // Decision happens at count L-1, the end pulse shows count L.
    localparam logic [CNT_W-1:0] THR_NAT_PLAIN = CNT_W'(FAST_NATIVE - 1);
    localparam logic [CNT_W-1:0] THR_LEG_PLAIN = CNT_W'(FAST_LEGACY - 1);
    localparam logic [CNT_W-1:0] THR_NAT_GATED = CNT_W'(FAST_NATIVE);
    localparam logic [CNT_W-1:0] THR_LEG_GATED = CNT_W'(FAST_LEGACY);
    localparam logic [CNT_W-1:0] MIN_NAT_GATED = CNT_W'(FAST_NATIVE + 1);
    localparam logic [CNT_W-1:0] MIN_LEG_GATED = CNT_W'(FAST_LEGACY + 1);
    localparam logic [CNT_W-1:0] CNT_MAX       = '1;

    term_state_e      state, state_nx;
    logic             gate_q, legacy_q, fast_q;
    logic             ack_hit, rdy_q;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] fast_thr;
    logic             ack_any, fast_ok, finish;

    // Termination rule
    always_comb begin
        ack_any  = ack_hit | ack_sync;
        unique case ({legacy_q, gate_q})
            2'b00:   fast_thr = THR_NAT_PLAIN;
            2'b01:   fast_thr = THR_NAT_GATED;
            2'b10:   fast_thr = THR_LEG_PLAIN;
            default: fast_thr = THR_LEG_GATED;
        endcase
        fast_ok  = fast_q && (cnt >= fast_thr);
        finish   = (ack_any || fast_ok) && (!gate_q || rdy_q);
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (cycle_start) state_nx = ST_RUN;
            ST_RUN:  if (finish)      state_nx = ST_DONE;
            ST_DONE:                  state_nx = ST_IDLE;
            default:                  state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Cycle context, sticky flags and clock counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q   <= 1'b0;
            legacy_q <= 1'b0;
            fast_q   <= 1'b0;
            ack_hit  <= 1'b0;
            rdy_q    <= 1'b0;
            cnt      <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    rdy_q <= rdy_sync;
                    if (cycle_start) begin
                        gate_q   <= rdy_en & ~dual_mode;
                        legacy_q <= legacy_mode;
                        fast_q   <= fast_req;
                        ack_hit  <= 1'b0;
                        cnt      <= CNT_W'(1);
                    end else begin
                        cnt      <= '0;
                    end
                end
                ST_RUN: begin
                    ack_hit <= ack_hit | ack_sync;
                    rdy_q   <= rdy_q | rdy_sync;
                    if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
                end
                ST_DONE: begin
                    rdy_q <= rdy_sync;
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        cycle_end    = (state == ST_DONE);
        cycle_clocks = cnt;
    end

    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_end |=> !cycle_end);

    assert_gate_needs_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_end && gate_q) |-> $past(rdy_q));

    assert_fast_gated_min_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_end && fast_q && gate_q) |->
            (cycle_clocks >= (legacy_q ? MIN_LEG_GATED : MIN_NAT_GATED)));

    assert_fast_plain_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_end && fast_q && !gate_q) |->
            (cycle_clocks <= (legacy_q ? CNT_W'(FAST_LEGACY) : CNT_W'(FAST_NATIVE))));

    assert_len_floor_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_end |-> (cycle_clocks >= CNT_W'(2)));
endmodule

// File: rtl/dma_rdy_term.sv
module dma_rdy_term #(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int FAST_NATIVE = 2,
    parameter int FAST_LEGACY = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rdy_en,
    input  logic             dual_mode,
    input  logic             legacy_mode,
    input  logic             fast_req,
    input  logic             ext_ack,
    input  logic             ext_rdy,
    input  logic             cycle_start,
    output logic             cycle_end,
    output logic [CNT_W-1:0] cycle_clocks
);
    logic ack_s, rdy_s;

    dma_async_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk(clk), .rst_n(rst_n), .din(ext_ack), .dout(ack_s)
    );

    dma_async_sync #(.STAGES(SYNC_STAGES)) u_rdy_sync (
        .clk(clk), .rst_n(rst_n), .din(ext_rdy), .dout(rdy_s)
    );

    dma_term_fsm #(
        .CNT_W(CNT_W), .FAST_NATIVE(FAST_NATIVE), .FAST_LEGACY(FAST_LEGACY)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .rdy_en(rdy_en), .dual_mode(dual_mode),
        .legacy_mode(legacy_mode), .fast_req(fast_req), .cycle_start(cycle_start),
        .ack_sync(ack_s), .rdy_sync(rdy_s),
        .cycle_end(cycle_end), .cycle_clocks(cycle_clocks)
    );
endmodule

// File: tb/dma_rdy_term_bench.sv
`timescale 1ns/1ps
module dma_rdy_term_bench;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             rdy_en = 1'b0, dual_mode = 1'b0, legacy_mode = 1'b0, fast_req = 1'b0;
    logic             ext_ack = 1'b0, ext_rdy = 1'b0, cycle_start = 1'b0;
    logic             cycle_end;
    logic [CNT_W-1:0] cycle_clocks;

    int    n_total = 0, n_fail = 0, ends_seen = 0;
    int    exp_q[$];
    string tag_q[$];

    always #2.5 clk = ~clk;

    dma_rdy_term u_dma_rdy_term (
        .clk(clk), .rst_n(rst_n), .rdy_en(rdy_en), .dual_mode(dual_mode),
        .legacy_mode(legacy_mode), .fast_req(fast_req), .ext_ack(ext_ack),
        .ext_rdy(ext_rdy), .cycle_start(cycle_start),
        .cycle_end(cycle_end), .cycle_clocks(cycle_clocks)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on each end pulse
    always @(negedge clk) begin
        if (rst_n && cycle_end) begin
            ends_seen++;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R10 unexpected end pulse", int'(cycle_clocks), 0);
            end else begin
                automatic int    e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                chk(int'(cycle_clocks) == e, t, int'(cycle_clocks), e);
            end
        end
    end

    // j/r: drive offset after start edge (-1 never, -2 held from before start)
    task automatic run_cycle(input bit gate, input bit dual, input bit leg, input bit fast,
                             input int j, input int r, input int stray,
                             input int exp, input string tag);
        int base;
        @(posedge clk); #1;
        rdy_en = gate; dual_mode = dual; legacy_mode = leg; fast_req = fast;
        ext_ack = 1'b0; ext_rdy = (r == -2);
        if (r == -2) begin
            repeat (3) @(posedge clk);
            #1;
        end
        exp_q.push_back(exp); tag_q.push_back(tag);
        base = ends_seen;
        cycle_start = 1'b1;
        @(posedge clk); #1;
        cycle_start = 1'b0;
        for (int k = 0; k < 60; k++) begin
            if (k == j) ext_ack = 1'b1;
            if (k == r) ext_rdy = 1'b1;
            cycle_start = (stray >= 0 && k == stray);
            @(posedge clk); #1;
            if (ends_seen > base) break;
        end
        cycle_start = 1'b0; ext_ack = 1'b0; ext_rdy = 1'b0; fast_req = 1'b0;
        repeat (4) @(posedge clk);
        #1;
        if (stray >= 0) chk(ends_seen == base + 1, "R10 stray start ignored", ends_seen - base, 1);
    endtask

    initial begin
        #(5.0 * 200000);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(cycle_end == 1'b0 && cycle_clocks == '0, "R11 reset state", int'(cycle_clocks), 0);
        #1 rst_n = 1'b1;
        repeat (3) @(posedge clk);

        // gate dual leg fast  j   r  stray exp
        run_cycle(0, 0, 0, 0, 0, -1, -1, 3, "R1 R9 ack alone k=0");
        run_cycle(0, 0, 0, 0, 3, -1, -1, 6, "R1 ack alone k=3");
        run_cycle(1, 0, 0, 0, 3,  2, -1, 6, "R3 ready one clock early");
        run_cycle(1, 0, 0, 0, 2,  2, -1, 6, "R4 ready same edge");
        run_cycle(1, 0, 0, 0, 1,  4, -1, 8, "R4 ready later");
        run_cycle(1, 0, 0, 0, 5,  0, -1, 8, "R2 waits for ack");
        run_cycle(0, 0, 0, 1, -1, -1, -1, 2, "R5 fast native plain");
        run_cycle(0, 0, 1, 1, -1, -1, -1, 3, "R5 fast legacy plain");
        run_cycle(1, 0, 0, 1, -1, -2, -1, 3, "R6 R7 fast native held ready");
        run_cycle(1, 0, 1, 1, -1, -2, -1, 4, "R6 R7 fast legacy held ready");
        run_cycle(1, 0, 0, 1, -1,  3, -1, 7, "R6 fast stretched by ready");
        run_cycle(1, 0, 0, 0, 0, -2, -1, 3, "R7 held ready ack k=0");
        run_cycle(1, 0, 0, 0, 4, -2, -1, 7, "R7 held ready ack k=4");
        run_cycle(1, 1, 0, 0, 1, -1, -1, 4, "R8 dual ignores ready enable");
        run_cycle(0, 0, 0, 0, 4, -1,  1, 7, "R10 cycle with stray start");

        // R11: reset in the middle of an open cycle
        @(posedge clk); #1;
        rdy_en = 1'b0; cycle_start = 1'b1;
        @(posedge clk); #1;
        cycle_start = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b0;
        @(negedge clk);
        chk(cycle_end == 1'b0 && cycle_clocks == '0, "R11 reset mid-cycle", int'(cycle_clocks), 0);
        #1 rst_n = 1'b1;
        repeat (6) @(posedge clk);
        #1;
        chk(exp_q.size() == 0, "R10 scoreboard drained", exp_q.size(), 0);

        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule